// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, address and control pins of a four-bank, 16-bit synchronous DRAM from the moment reset is applied until the memory can accept normal traffic. It first holds the clock enable and the data masks high and issues only no-operation commands for a power-up delay. The length of that delay is derived from a clock-frequency parameter and a delay given in microseconds. It then closes every bank with one precharge and runs a programmable number of auto-refresh cycles. It then writes the mode register from an input word and pads with no-operations before it raises a ready flag.

Every timing gap (precharge recovery, refresh cycle time, mode-register settle time) is a parameter in clock cycles. Minimum counts (two refreshes, two settle cycles, one recovery cycle) are enforced by raising smaller parameter values. A synchronous reset at any moment drops the ready flag and restarts the whole sequence from the power-up wait. Once ready, the block keeps issuing no-operations until the next reset, and the normal memory controller takes over the bus.

Top module: `sdram_powerup_seq`

## Requirements
- R1: The command is carried on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} with the encodings no-operation = 4'b0111, precharge = 4'b0010, auto-refresh = 4'b0001 and mode-register load = 4'b0000. Every output is registered and changes only after a rising clock edge.
- R2: After reset is released, exactly WAIT_CYC = ceil(CLK_HZ * WAIT_US / 1e6) no-operation cycles are issued before the first other command. During them sd_cke and every sd_dqm bit are 1 and sd_addr and sd_ba are 0.
- R3: While rst is high, the outputs show a no-operation with sd_cke = 1, all sd_dqm bits 1, sd_addr = 0, sd_ba = 0 and init_done = 0.
- R4: The wait ends with exactly one precharge that has address bit 10 set (all banks) and all other address and bank bits zero. It is followed by max(TRP_CYC,1) no-operation cycles.
- R5: After the precharge gap come max(REF_COUNT,2) auto-refresh commands. Each one is followed by max(TRC_CYC,1) no-operation cycles.
- R6: After the last refresh gap comes one mode-register load, with sd_addr equal to mode_word and sd_ba = 0.
- R7: The mode-register load is followed by max(TMRD_CYC,2) no-operation cycles with init_done low. init_done rises on the next cycle.
- R8: Once init_done is high, it stays high and every cycle is a no-operation with sd_addr = 0, whatever mode_word does, until reset.
- R9: A reset asserted at any point, including mid-sequence or after ready, makes the outputs show a no-operation with init_done = 0 after the next rising edge. The following release replays the complete sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_word | input | 12 | Value written into the memory's mode register |
| sd_cke | output | 1 | Clock enable to the memory, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 2 | Byte data masks, held high |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row/column/mode address |
| init_done | output | 1 | High once the memory is ready for normal accesses |

## Verification
The full sequence is run twice with two different mode words (0x237 and 0x0C8). Every output cycle is compared, so a wrong field position or a stale mode value is told apart from a correct load. A reset is also applied in the middle of the refresh phase, and the rerun that follows tells a true restart from a sequence that resumes where it stopped. The parameters are set to three refreshes and a three-cycle settle gap, which separates a counted loop from one hard-wired at the minimum. A mode_word change after ready, and a reset after ready, check that the finished state ignores its input and that the flag is actually cleared.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_PRE,
    PH_TRP,
    PH_REF,
    PH_TRC,
    PH_LMR,
    PH_TMRD,
    PH_DONE
  } init_phase_e;

  // Power-up delay in clock cycles, rounded up.
  function automatic int unsigned powerup_cycles(int unsigned hz, int unsigned us);
    logic [63:0] prod;
    prod = (64'(hz) * 64'(us) + 64'd999_999) / 64'd1_000_000;
    return prod[31:0];
  endfunction

  function automatic int unsigned clamp_min(int unsigned v, int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned width_for(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned RST_VAL = 4999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= CNT_W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2: once at zero and not reloaded, the timer holds at zero
  a_r2_timer_holds: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired)
    else $error("a_r2_timer_holds");

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 5000,
  parameter int unsigned TRP      = 1,
  parameter int unsigned TRC      = 1,
  parameter int unsigned TMRD     = 2,
  parameter int unsigned REFS     = 2,
  parameter int unsigned CNT_W    = 13
) (
  input  logic        clk,
  input  logic        rst,
  output init_phase_e phase,
  output logic        wait_elapsed,
  output logic        ref_issue
);

  localparam int unsigned RC_W = width_for(REFS);

  init_phase_e      phase_q, phase_d;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expired;
  logic [RC_W-1:0]  ref_cnt;
  logic             refs_all_done;

  sdram_gap_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  assign refs_all_done = (ref_cnt == RC_W'(REFS));
  assign wait_elapsed  = (phase_q == PH_WAIT) && t_expired;
  assign ref_issue     = (phase_q == PH_REF);

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    case (phase_q)
      PH_WAIT: if (t_expired) phase_d = PH_PRE;
      PH_PRE: begin
        phase_d = PH_TRP;
        t_load  = 1'b1;
        t_val   = CNT_W'(TRP - 1);
      end
      PH_TRP:  if (t_expired) phase_d = PH_REF;
      PH_REF: begin
        phase_d = PH_TRC;
        t_load  = 1'b1;
        t_val   = CNT_W'(TRC - 1);
      end
      PH_TRC:  if (t_expired) phase_d = refs_all_done ? PH_LMR : PH_REF;
      PH_LMR: begin
        phase_d = PH_TMRD;
        t_load  = 1'b1;
        t_val   = CNT_W'(TMRD - 1);
      end
      PH_TMRD: if (t_expired) phase_d = PH_DONE;
      PH_DONE: phase_d = PH_DONE;
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_WAIT;
      ref_cnt <= '0;
    end else begin
      phase_q <= phase_d;
      if (ref_issue) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  assign phase = phase_q;

  // R5: the refresh count never passes its target
  a_r5_ref_bound: assert property (@(posedge clk) disable iff (rst)
    ref_cnt <= RC_W'(REFS))
    else $error("a_r5_ref_bound");

  // R6: the mode load is reached only after every refresh was issued
  a_r6_lmr_after_refs: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LMR) |-> refs_all_done)
    else $error("a_r6_lmr_after_refs");

endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BA_W    = 2,
  parameter int unsigned DQM_W   = 2,
  parameter int unsigned ALL_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  init_phase_e       phase,
  input  logic [ADDR_W-1:0] mode_word,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              done
);

  logic [3:0]        cmd_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    case (phase)
      PH_PRE: begin
        cmd_d           = CMD_PRE;
        addr_d[ALL_BIT] = 1'b1;
      end
      PH_REF: cmd_d = CMD_REF;
      PH_LMR: begin
        cmd_d  = CMD_LMR;
        addr_d = mode_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
      cke  <= 1'b1;
      dqm  <= '1;
      done <= 1'b0;
    end else begin
      cmd  <= cmd_d;
      addr <= addr_d;
      ba   <= '0;
      cke  <= 1'b1;
      dqm  <= '1;
      done <= (phase == PH_DONE);
    end
  end

  // R1: only the four defined command codes appear on the pins
  a_r1_cmd_legal: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NOP) || (cmd == CMD_PRE) || (cmd == CMD_REF) || (cmd == CMD_LMR))
    else $error("a_r1_cmd_legal");

  // R4: precharge always selects all banks
  a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> addr[ALL_BIT])
    else $error("a_r4_pre_all_banks");

  // R6: mode load uses bank address zero
  a_r6_lmr_bank_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LMR) |-> (ba == '0))
    else $error("a_r6_lmr_bank_zero");

  // R8: ready implies idle commands
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd == CMD_NOP))
    else $error("a_r8_done_idle");

  // R8: ready stays up until reset
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done)
    else $error("a_r8_done_sticky");

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned WAIT_US   = 100,
  parameter int unsigned REF_COUNT = 2,
  parameter int unsigned TRP_CYC   = 2,
  parameter int unsigned TRC_CYC   = 4,
  parameter int unsigned TMRD_CYC  = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned DQM_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int unsigned WAIT_CYC = clamp_min(powerup_cycles(CLK_HZ, WAIT_US), 1);
  localparam int unsigned TRP      = clamp_min(TRP_CYC, 1);
  localparam int unsigned TRC      = clamp_min(TRC_CYC, 1);
  localparam int unsigned TMRD     = clamp_min(TMRD_CYC, 2);
  localparam int unsigned REFS     = clamp_min(REF_COUNT, 2);
  localparam int unsigned CNT_W    = width_for(max4(WAIT_CYC, TRP, TRC, TMRD));
  localparam int unsigned ALL_BIT  = 10;

  init_phase_e phase;
  logic        wait_elapsed;
  logic        ref_issue;
  logic [3:0]  cmd_pins;
  logic        wait_seen;

  sdram_init_fsm #(
    .WAIT_CYC (WAIT_CYC),
    .TRP      (TRP),
    .TRC      (TRC),
    .TMRD     (TMRD),
    .REFS     (REFS),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .phase        (phase),
    .wait_elapsed (wait_elapsed),
    .ref_issue    (ref_issue)
  );

  sdram_cmd_reg #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .DQM_W   (DQM_W),
    .ALL_BIT (ALL_BIT)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .mode_word (mode_word),
    .cmd       (cmd_pins),
    .addr      (sd_addr),
    .ba        (sd_ba),
    .cke       (sd_cke),
    .dqm       (sd_dqm),
    .done      (init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins;

  // Event record used by the check below: the power-up wait has run out.
  always_ff @(posedge clk) begin
    if (rst)               wait_seen <= 1'b0;
    else if (wait_elapsed) wait_seen <= 1'b1;
  end

  // R2: no command other than a no-operation before the wait has elapsed
  a_r2_no_early_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins != CMD_NOP) |-> wait_seen)
    else $error("a_r2_no_early_cmd");

  // R5: a refresh on the pins is never adjacent to another refresh
  a_r5_ref_spaced: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins == CMD_REF) |=> (cmd_pins == CMD_NOP))
    else $error("a_r5_ref_spaced");

endmodule

// File: tb/tb_sdram_powerup_seq.sv
module tb_sdram_powerup_seq;

  localparam int CLK_MHZ = 50;
  localparam int WAIT_US = 100;
  localparam int REFS    = 3;
  localparam int TRP     = 2;
  localparam int TRC     = 4;
  localparam int TMRD    = 3;
  localparam int WAIT_N  = CLK_MHZ * WAIT_US;   // exact for a whole-MHz clock

  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_LMR = 4'b0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mode_word = 12'h000;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0]  sd_dqm, sd_ba;
  logic [11:0] sd_addr;

  always #10 clk = ~clk;   // 50 MHz

  sdram_powerup_seq #(
    .CLK_HZ    (CLK_MHZ * 1_000_000),
    .WAIT_US   (WAIT_US),
    .REF_COUNT (REFS),
    .TRP_CYC   (TRP),
    .TRC_CYC   (TRC),
    .TMRD_CYC  (TMRD)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .mode_word (mode_word),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_dqm    (sd_dqm),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .init_done (init_done)
  );

  typedef struct {
    logic [21:0] word;
    int          req;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  logic mon_en   = 1'b0;

  // {cmd[3:0], ba[1:0], addr[11:0], done, cke, dqm[1:0]}
  function automatic logic [21:0] pins_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, init_done, sd_cke, sd_dqm};
  endfunction

  function automatic logic [21:0] make_word(logic [3:0] c, logic [11:0] a, logic d);
    return {c, 2'b00, a, d, 1'b1, 2'b11};
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input logic [21:0] act, input logic [21:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [11:0] a, input logic d, input int req);
    exp_t e;
    e.word = make_word(c, a, d);
    e.req  = req;
    sb.push_back(e);
  endtask

  // Driver: expected pin stream for one full run after reset release.
  task automatic queue_sequence(input logic [11:0] mw);
    for (int i = 0; i < WAIT_N; i++) push(K_NOP, 12'h000, 1'b0, 2);   // R2
    push(K_PRE, 12'h400, 1'b0, 4);                                     // R4 (bit 10)
    for (int i = 0; i < TRP; i++) push(K_NOP, 12'h000, 1'b0, 4);
    for (int r = 0; r < REFS; r++) begin                              // R5
      push(K_REF, 12'h000, 1'b0, 5);
      for (int i = 0; i < TRC; i++) push(K_NOP, 12'h000, 1'b0, 5);
    end
    push(K_LMR, mw, 1'b0, 6);                                          // R6
    for (int i = 0; i < TMRD; i++) push(K_NOP, 12'h000, 1'b0, 7);     // R7
    for (int i = 0; i < 6; i++) push(K_NOP, 12'h000, 1'b1, 8);        // R8
  endtask

  // Monitor: compares each cycle's pins against the next expected item.
  always @(negedge clk) begin
    if (mon_en && sb.size() != 0) begin
      exp_t e;
      logic [21:0] act;
      e   = sb.pop_front();
      act = pins_now();
      check(act === e.word, e.req, "pin stream", act, e.word);
    end
  end

  task automatic check_reset_state(input int req, input string what);
    logic [21:0] exp;
    exp = make_word(K_NOP, 12'h000, 1'b0);
    check(pins_now() === exp, req, what, pins_now(), exp);
  endtask

  task automatic run_to_done(input logic [11:0] mw);
    mode_word = mw;
    queue_sequence(mw);
    rst = 1'b0;
    @(posedge clk);
    mon_en = 1'b1;
    wait (sb.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: state held while reset is high
    check_reset_state(3, "reset state");
    // R1: no-operation encoding on the command pins during reset
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, 1, "nop code",
          22'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 22'(4'b0111));

    // First full run, mode word A (R1..R8 through the scoreboard)
    run_to_done(12'h237);

    // R8: a new mode word after ready is ignored
    mode_word = 12'hFFF;
    repeat (3) @(negedge clk);
    check(pins_now() === make_word(K_NOP, 12'h000, 1'b1), 8, "mode ignored after ready",
          pins_now(), make_word(K_NOP, 12'h000, 1'b1));

    // R9: reset after ready clears init_done on the next edge
    rst = 1'b1;
    @(negedge clk);
    check_reset_state(9, "reset after ready");

    // R9: reset in the middle of the refresh phase
    rst = 1'b0;
    repeat (WAIT_N + TRP + 4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state(9, "reset mid-sequence");
    @(negedge clk);

    // Rerun from scratch with mode word B (R9 restart, R6 distinct value)
    run_to_done(12'h0C8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule